// File: doc/BRIEF.md
# Configurable Serial Shifter Engine

This block moves bytes between a parallel valid/ready interface and one serial data line. An optional clock line sits beside the data line. A small set of configuration inputs selects one of three line disciplines. The first is asynchronous framing with adjustable start and stop bit counts and 16x oversampled reception. The second is NRZI line coding of the kind USB uses. The third is a clocked synchronous mode. The transmit and receive halves are independent and may be looped back on each other.

Framing above the bit level is left to software. That covers preambles, CRCs and the point at which a protocol switches mode. Parity is not computed. When the parity slot is enabled, the transmitter sends the bit given on `tx_par` and the receiver reports what it saw on `rx_par`. All bit timing comes from one 16-bit divider. A subtick lasts `cfg_div+1` clocks, and a bit lasts 16 subticks. Data is always shifted least significant bit first. Configuration is expected to change only while both halves are idle.

Top module: `ssx_engine`

## Requirements
- R1: With cfg_mode=0 (asynchronous), an accepted byte is sent as start bits (low), then the 8 data bits LSB first, then the parity slot when enabled, then stop bits (high). Each bit lasts 16*(cfg_div+1) clocks, and the line is high when idle.
- R2: The field cfg_start=n gives n+1 start bits and cfg_stop=n gives n+1 stop bits, for both transmit and receive.
- R3: The asynchronous receiver starts on a falling edge of the line. Each bit is decided by a majority vote of samples at subticks 7, 8 and 9. A start bit that votes high aborts the frame with no byte delivered, and a one-clock glitch inside a bit does not alter the received byte.
- R4: If any stop bit votes low, the byte is delivered with rx_ferr=1; otherwise rx_ferr=0.
- R5: With cfg_par_en=1, the slot after the data carries tx_par unchanged, and the receiver reports that slot on rx_par; no parity is computed.
- R6: With cfg_mode=1 (NRZI), each data bit 0 toggles the line and each 1 holds it. No start or stop bits are sent, and the line holds its level between bytes.
- R7: The NRZI receiver starts on any line transition and decodes 8 bits, giving 0 where the voted level changed and 1 where it held.
- R8: With cfg_mode=2 (synchronous), sclk_out rests at the level cfg_clk_fall and moves to the other level 8 subticks after each data change. The data line changes only while sclk_out is at rest. In the other modes sclk_out stays at rest.
- R9: In synchronous mode the receiver samples sd_in on rising edges of sclk_in when cfg_clk_fall=0 and on falling edges when it is 1. After every 8 samples it delivers a byte, LSB first.
- R10: tx_ready is low from acceptance (tx_valid and tx_ready at a clock edge) to the end of the frame. rx_valid stays high until a cycle with rx_ready high.
- R11: After reset, tx_ready=1, rx_valid=0, sd_out=1 and sclk_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 asynchronous, 1 NRZI, 2 or 3 synchronous |
| cfg_div | input | 16 | Subtick length minus one, in clocks |
| cfg_start | input | 2 | Start bit count minus one |
| cfg_stop | input | 2 | Stop bit count minus one |
| cfg_par_en | input | 1 | Enable the parity slot |
| cfg_clk_fall | input | 1 | Clock rest level and receive edge select |
| tx_data | input | 8 | Byte to send |
| tx_par | input | 1 | Value for the parity slot |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle, byte accepted when valid |
| rx_data | output | 8 | Received byte |
| rx_par | output | 1 | Received parity slot |
| rx_ferr | output | 1 | Stop bit missing on this byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Consumer takes the byte |
| sd_out | output | 1 | Serial data out |
| sclk_out | output | 1 | Serial clock out |
| sd_in | input | 1 | Serial data in |
| sclk_in | input | 1 | Serial clock in |

## Verification
The bench targets the following corner cases:
- Glitch handling. A start pulse too short to reach mid-bit must be dropped; a design that trusted the edge alone would deliver a spurious byte. A single-clock spike inside a data bit must not flip it; a design that takes one sample would flip that bit.
- Stop-bit checking. A low stop bit, including the second of two, must raise the error flag. A design that checked only the first stop bit would miss the second case.
- Synchronous receive edge. A clocked byte is driven with different data around the rising and the falling edge, so sampling on the wrong edge returns the other byte.
- NRZI and clock phase. The transmitted line is compared bit by bit with an independently encoded NRZI stream. Clock phase is checked at a quarter and three quarters of each bit, which exposes an inverted coding rule or a clock edge that coincides with the data change.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int DIV_W = 16;
  localparam int FLD_W = 2;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_NRZI  = 2'd1,
    MODE_SYNC  = 2'd2
  } mode_e;

  typedef struct packed {
    mode_e            mode;
    logic [DIV_W-1:0] div;
    logic [FLD_W-1:0] start_m1;
    logic [FLD_W-1:0] stop_m1;
    logic             par_en;
    logic             clk_fall;
  } cfg_t;
endpackage

// File: rtl/ssx_tx.sv
module ssx_tx
  import ssx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  cfg_t          cfg,
  input  logic [DW-1:0] data,
  input  logic          par,
  input  logic          valid,
  output logic          ready,
  output logic          sd,
  output logic          sclk
);
  localparam int MAXF = 1 << FLD_W;
  localparam int FW   = 2 * MAXF + DW + 1;
  localparam int LW   = $clog2(FW + 1);
  localparam int SW   = $clog2(OVS);

  logic             busy;
  logic [FW-1:0]    sh, frame;
  logic [LW-1:0]    left, flen;
  logic [DIV_W-1:0] pre;
  logic [SW-1:0]    sub;
  logic [DW:0]      body;

  always_comb begin
    body = {cfg.par_en ? par : 1'b1, data};
    if (cfg.mode == MODE_ASYNC) begin
      frame = {{(FW-DW-1){1'b1}}, body} << (int'(cfg.start_m1) + 1);
      flen  = LW'(cfg.start_m1) + LW'(cfg.stop_m1) + LW'(DW + 2) + LW'(cfg.par_en);
    end else begin
      frame = FW'(data);
      flen  = LW'(DW);
    end
  end

  function automatic logic enc(input logic b, input logic cur, input mode_e m);
    return (m == MODE_NRZI) ? (b ? cur : ~cur) : b;
  endfunction

  assign ready = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sd   <= 1'b1;
      sclk <= 1'b0;
      pre  <= '0;
      sub  <= '0;
      sh   <= '0;
      left <= '0;
    end else if (!busy) begin
      sclk <= cfg.clk_fall;
      if (cfg.mode == MODE_ASYNC) sd <= 1'b1;
      if (valid) begin
        busy <= 1'b1;
        pre  <= cfg.div;
        sub  <= '0;
        sd   <= enc(frame[0], sd, cfg.mode);
        sh   <= frame >> 1;
        left <= flen - LW'(1);
      end
    end else if (pre == '0) begin
      pre <= cfg.div;
      sub <= (sub == SW'(OVS-1)) ? '0 : sub + SW'(1);
      if (sub == SW'(OVS/2-1) && cfg.mode == MODE_SYNC) sclk <= ~cfg.clk_fall;
      if (sub == SW'(OVS-1)) begin
        sclk <= cfg.clk_fall;
        if (left == '0) begin
          busy <= 1'b0;
        end else begin
          sd   <= enc(sh[0], sd, cfg.mode);
          sh   <= sh >> 1;
          left <= left - LW'(1);
        end
      end
    end else begin
      pre <= pre - DIV_W'(1);
    end
  end
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx
  import ssx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  cfg_t          cfg,
  input  logic          sd_in,
  input  logic          sclk_in,
  input  logic          rdy,
  output logic [DW-1:0] data,
  output logic          par,
  output logic          ferr,
  output logic          valid
);
  localparam int MAXF = 1 << FLD_W;
  localparam int FW   = 2 * MAXF + DW + 1;
  localparam int LW   = $clog2(FW + 1);
  localparam int SW   = $clog2(OVS);
  localparam int CW   = $clog2(DW);

  logic [2:0]       sdq, ckq, vote;
  logic             act, refl, ferr_q, par_q, maj, bitv, ck_act, trig, nrzi;
  logic [LW-1:0]    pos, last, ns;
  logic [DIV_W-1:0] pre;
  logic [SW-1:0]    sub;
  logic [DW-1:0]    shd, shd_n;
  logic [CW-1:0]    scnt;

  assign nrzi   = (cfg.mode == MODE_NRZI);
  assign ns     = LW'(cfg.start_m1) + LW'(1);
  assign maj    = (vote[0] & vote[1]) | (vote[0] & vote[2]) | (vote[1] & vote[2]);
  assign bitv   = nrzi ? (maj == refl) : maj;
  assign shd_n  = {bitv, shd[DW-1:1]};
  assign ck_act = cfg.clk_fall ? (ckq[2] & ~ckq[1]) : (~ckq[2] & ckq[1]);
  assign trig   = nrzi ? (sdq[2] ^ sdq[1]) : (sdq[2] & ~sdq[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sdq <= '1; ckq <= '0; vote <= '0;
      act <= 1'b0; refl <= 1'b0; ferr_q <= 1'b0; par_q <= 1'b0;
      pos <= '0; last <= '0; pre <= '0; sub <= '0; shd <= '0; scnt <= '0;
      data <= '0; par <= 1'b0; ferr <= 1'b0; valid <= 1'b0;
    end else begin
      sdq <= {sdq[1:0], sd_in};
      ckq <= {ckq[1:0], sclk_in};
      if (valid && rdy) valid <= 1'b0;
      if (cfg.mode == MODE_SYNC) begin
        act <= 1'b0;
        if (ck_act) begin
          shd  <= {sdq[1], shd[DW-1:1]};
          scnt <= scnt + CW'(1);
          if (scnt == CW'(DW-1)) begin
            data  <= {sdq[1], shd[DW-1:1]};
            ferr  <= 1'b0;
            valid <= 1'b1;
          end
        end
      end else if (!act) begin
        scnt <= '0;
        if (trig) begin
          act    <= 1'b1;
          pos    <= '0;
          pre    <= cfg.div;
          sub    <= '0;
          refl   <= sdq[2];
          ferr_q <= 1'b0;
          last   <= nrzi ? LW'(DW-1)
                         : ns + LW'(cfg.stop_m1) + LW'(DW) + LW'(cfg.par_en);
        end
      end else if (pre == '0) begin
        pre <= cfg.div;
        sub <= (sub == SW'(OVS-1)) ? '0 : sub + SW'(1);
        if (sub >= SW'(OVS/2-1) && sub <= SW'(OVS/2+1)) vote <= {vote[1:0], sdq[1]};
        if (sub == SW'(OVS-1)) begin
          pos <= pos + LW'(1);
          if (nrzi) begin
            refl <= maj;
            shd  <= shd_n;
          end else if (pos < ns) begin
            if (maj) act <= 1'b0;
          end else if (pos < ns + LW'(DW)) begin
            shd <= shd_n;
          end else if (cfg.par_en && pos == ns + LW'(DW)) begin
            par_q <= maj;
          end else if (!maj) begin
            ferr_q <= 1'b1;
          end
          if (pos == last) begin
            act   <= 1'b0;
            valid <= 1'b1;
            data  <= nrzi ? shd_n : shd;
            ferr  <= ~nrzi & (ferr_q | ~maj);
            par   <= par_q;
          end
        end
      end else begin
        pre <= pre - DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/ssx_engine.sv
module ssx_engine
  import ssx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [FLD_W-1:0] cfg_start,
  input  logic [FLD_W-1:0] cfg_stop,
  input  logic             cfg_par_en,
  input  logic             cfg_clk_fall,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_par,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [DW-1:0]    rx_data,
  output logic             rx_par,
  output logic             rx_ferr,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             sd_out,
  output logic             sclk_out,
  input  logic             sd_in,
  input  logic             sclk_in
);
  cfg_t cfg;

  always_comb begin
    cfg.mode     = (cfg_mode == 2'd3) ? MODE_SYNC : mode_e'(cfg_mode);
    cfg.div      = cfg_div;
    cfg.start_m1 = cfg_start;
    cfg.stop_m1  = cfg_stop;
    cfg.par_en   = cfg_par_en;
    cfg.clk_fall = cfg_clk_fall;
  end

  ssx_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .cfg(cfg), .data(tx_data), .par(tx_par),
    .valid(tx_valid), .ready(tx_ready), .sd(sd_out), .sclk(sclk_out)
  );

  ssx_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .cfg(cfg), .sd_in(sd_in), .sclk_in(sclk_in),
    .rdy(rx_ready), .data(rx_data), .par(rx_par), .ferr(rx_ferr), .valid(rx_valid)
  );
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       cfg_clk_fall,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       sd_out,
  input logic       sclk_out
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0 && $rose(tx_ready)) |-> sd_out);

  p_nrzi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd1 && $stable(cfg_mode) && tx_ready && $past(tx_ready)) |-> $stable(sd_out));

  p_data_at_rest_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode[1] && $stable(cfg_mode) && $stable(cfg_clk_fall) && !$stable(sd_out))
      |-> sclk_out == cfg_clk_fall);

  p_clk_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode[1] && $stable(cfg_mode) && $stable(cfg_clk_fall)) |=> $stable(sclk_out));

  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_ready) |-> $past(tx_valid));

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> rx_valid);
endmodule

bind ssx_engine ssx_checker u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_clk_fall(cfg_clk_fall),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .sd_out(sd_out), .sclk_out(sclk_out)
);

// File: tb/tb_ssx_engine.sv
module tb_ssx_engine;
  localparam int DIV = 1;
  localparam int P   = 16 * (DIV + 1);
  localparam int NV  = 11;
  // fields: mode[16:15] start[14:13] stop[12:11] par_en[10] par[9] clk_fall[8] data[7:0]
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h55},
    {2'd0, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 8'hA3},
    {2'd0, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 8'hFF},
    {2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h5A},
    {2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hFE},
    {2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h96},
    {2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 8'h3C},
    {2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h01},
    {2'd0, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 8'h7E}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'd0;
  logic [15:0] cfg_div = 16'(DIV);
  logic [1:0]  cfg_start = 2'd0, cfg_stop = 2'd0;
  logic        cfg_par_en = 1'b0, cfg_clk_fall = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_par = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
  logic        tx_ready, rx_par, rx_ferr, rx_valid, sd_out, sclk_out;
  logic [7:0]  rx_data;
  logic        lb = 1'b1, drv_sd = 1'b1, drv_ck = 1'b0;
  logic        sd_in, sclk_in;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  assign sd_in   = lb ? sd_out : drv_sd;
  assign sclk_in = lb ? sclk_out : drv_ck;

  ssx_engine dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_div(cfg_div), .cfg_start(cfg_start),
    .cfg_stop(cfg_stop), .cfg_par_en(cfg_par_en), .cfg_clk_fall(cfg_clk_fall),
    .tx_data(tx_data), .tx_par(tx_par), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_par(rx_par), .rx_ferr(rx_ferr), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .sd_out(sd_out), .sclk_out(sclk_out), .sd_in(sd_in), .sclk_in(sclk_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_rx();
    for (int g = 0; g < 4 * P && !rx_valid; g++) @(negedge clk);
  endtask

  task automatic take_rx();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic drive_bits(input logic [31:0] bits, input int len, input int gbit);
    for (int i = 0; i < len; i++) begin
      drv_sd = bits[i];
      if (i == gbit) begin
        repeat (P / 2) @(negedge clk);
        drv_sd = ~bits[i];
        @(negedge clk);
        drv_sd = bits[i];
        repeat (P / 2 - 1) @(negedge clk);
      end else begin
        repeat (P) @(negedge clk);
      end
    end
    drv_sd = 1'b1;
  endtask

  task automatic run_vec(input int k);
    logic [16:0] v;
    logic [1:0]  md, st, sp;
    logic        pe, pv, cf, lvl, rest, actv, line_bad, clk_bad;
    logic [7:0]  d;
    logic [31:0] eb, gb;
    int          len, ns;
    string       tag;
    v = VEC[k];
    md = v[16:15]; st = v[14:13]; sp = v[12:11]; pe = v[10]; pv = v[9]; cf = v[8]; d = v[7:0];
    @(negedge clk);
    cfg_mode = md; cfg_start = st; cfg_stop = sp; cfg_par_en = pe; cfg_clk_fall = cf;
    repeat (4) @(negedge clk);
    lvl = sd_out;
    eb = '0; gb = '0;
    if (md == 2'd0) begin
      ns  = int'(st) + 1;
      len = ns + 8 + int'(pe) + int'(sp) + 1;
      for (int i = 0; i < len; i++) begin
        if (i < ns)                eb[i] = 1'b0;
        else if (i < ns + 8)       eb[i] = d[i - ns];
        else if (pe && i == ns + 8) eb[i] = pv;
        else                       eb[i] = 1'b1;
      end
      tag = (st != 0 || sp != 0) ? "R2" : "R1";
    end else begin
      len = 8;
      for (int i = 0; i < 8; i++) begin
        if (md == 2'd1) begin
          if (!d[i]) lvl = ~lvl;
          eb[i] = lvl;
        end else begin
          eb[i] = d[i];
        end
      end
      tag = (md == 2'd1) ? "R6" : "R8";
    end
    rest = cf;
    actv = (md == 2'd2) ? ~cf : cf;
    tx_data = d; tx_par = pv; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    line_bad = 1'b0; clk_bad = 1'b0;
    for (int i = 0; i < len; i++) begin
      repeat (P / 4) @(negedge clk);
      if (sclk_out !== rest) clk_bad = 1'b1;
      if (i == 0) chk(tx_ready == 1'b0, "R10 ready low in frame", 32'(tx_ready), 0);
      repeat (P / 2) @(negedge clk);
      gb[i] = sd_out;
      if (sd_out !== eb[i]) line_bad = 1'b1;
      if (sclk_out !== actv) clk_bad = 1'b1;
      repeat (P / 4) @(negedge clk);
    end
    chk(!line_bad, {tag, " line bits"}, gb, eb);
    chk(!clk_bad, "R8 clock phase", 32'(sclk_out), 32'(actv));
    wait_rx();
    repeat (5) @(negedge clk);
    chk(rx_valid == 1'b1, "R10 rx held", 32'(rx_valid), 1);
    chk(rx_data == d, (md == 2'd0) ? "R3 rx byte" : (md == 2'd1) ? "R7 rx byte" : "R9 rx byte",
        32'(rx_data), 32'(d));
    if (md == 2'd0) chk(rx_ferr == 1'b0, "R4 no ferr", 32'(rx_ferr), 0);
    if (md == 2'd0 && pe) chk(rx_par == pv, "R5 parity slot", 32'(rx_par), 32'(pv));
    take_rx();
    chk(rx_valid == 1'b0, "R10 rx taken", 32'(rx_valid), 0);
  endtask

  task automatic clock_byte(input logic [7:0] a, input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      drv_sd = a[i];
      repeat (6) @(negedge clk);
      drv_ck = 1'b1;
      repeat (6) @(negedge clk);
      drv_sd = b[i];
      repeat (6) @(negedge clk);
      drv_ck = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R11 tx_ready", 32'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R11 rx_valid", 32'(rx_valid), 0);
    chk(sd_out == 1'b1, "R11 sd_out", 32'(sd_out), 1);
    chk(sclk_out == 1'b0, "R11 sclk_out", 32'(sclk_out), 0);

    for (int k = 0; k < NV; k++) run_vec(k);

    // asynchronous receive driven by the bench
    cfg_mode = 2'd0; cfg_start = 2'd0; cfg_stop = 2'd0; cfg_par_en = 1'b0; cfg_clk_fall = 1'b0;
    drv_sd = 1'b1;
    lb = 1'b0;
    repeat (10) @(negedge clk);

    // R3: short start pulse is rejected
    drv_sd = 1'b0;
    repeat (4) @(negedge clk);
    drv_sd = 1'b1;
    repeat (12 * P) @(negedge clk);
    chk(rx_valid == 1'b0, "R3 short start rejected", 32'(rx_valid), 0);

    // R3: one-clock glitch inside a data bit is outvoted
    drive_bits({22'h0, 1'b1, 8'hA5, 1'b0}, 10, 4);
    wait_rx();
    chk(rx_valid == 1'b1 && rx_data == 8'hA5, "R3 glitch outvoted", 32'(rx_data), 32'hA5);
    chk(rx_ferr == 1'b0, "R4 clean stop", 32'(rx_ferr), 0);
    take_rx();

    // R4: low stop bit
    repeat (P) @(negedge clk);
    drive_bits({22'h0, 1'b0, 8'h3C, 1'b0}, 10, -1);
    wait_rx();
    chk(rx_valid == 1'b1 && rx_data == 8'h3C, "R4 byte with bad stop", 32'(rx_data), 32'h3C);
    chk(rx_ferr == 1'b1, "R4 ferr set", 32'(rx_ferr), 1);
    take_rx();

    // R2: second of two stop bits low
    cfg_stop = 2'd1;
    repeat (2 * P) @(negedge clk);
    drive_bits({21'h0, 1'b0, 1'b1, 8'h5A, 1'b0}, 11, -1);
    wait_rx();
    chk(rx_valid == 1'b1 && rx_data == 8'h5A, "R2 byte two stops", 32'(rx_data), 32'h5A);
    chk(rx_ferr == 1'b1, "R2 second stop checked", 32'(rx_ferr), 1);
    take_rx();
    cfg_stop = 2'd0;
    repeat (P) @(negedge clk);

    // R9: receive edge selection with distinct data at each edge
    drv_ck = 1'b0;
    repeat (5) @(negedge clk);
    cfg_mode = 2'd2; cfg_clk_fall = 1'b0;
    repeat (5) @(negedge clk);
    clock_byte(8'h6B, 8'h94);
    repeat (5) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 8'h6B, "R9 rising edge sample", 32'(rx_data), 32'h6B);
    take_rx();
    cfg_clk_fall = 1'b1;
    repeat (5) @(negedge clk);
    clock_byte(8'h6B, 8'h94);
    repeat (5) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 8'h94, "R9 falling edge sample", 32'(rx_data), 32'h94);
    take_rx();

    done = 1'b1;
    summary();
  end
endmodule